// File: doc/BRIEF.md
# Configuration Image Checksum Validator

This block checks the integrity of a stored configuration image held in a word-addressed non-volatile memory. After a start pulse it fetches a fixed run of words, word 0 through word `NUM_WORDS-1`, through a simple request/response read port. It adds each returned word into a running sum that is kept to `DATA_W` bits and wraps. When the last word has arrived it compares the sum with a fixed signature value. With the default parameters this is 64 words of 16 bits, and the signature is 0xBABA.

Only one read is in flight at any time. The next address goes out only after the previous response has come back. If any response carries the error flag, the check stops at once and reports an error instead of a pass or fail verdict. The verdict (`done`, `pass`, `error`) holds until the next accepted start. A start pulse that arrives while a check is running has no effect.

Top module: `img_sum_checker`

## Requirements
- R1: After reset `busy`, `done`, `pass`, `error` and `rd_req` are all 0.
- R2: The block requests word addresses 0, 1, 2, … `NUM_WORDS-1` in increasing order. `rd_req` is a one-cycle pulse, and a new request is never issued while an earlier one has not yet been answered by `rd_ack`.
- R3: The sum is `DATA_W` bits wide and wraps modulo 2^`DATA_W`. Carries out of the top bit are discarded.
- R4: When the last word is accepted without error, `done` rises, and `pass` is 1 exactly when the wrapped sum of all words equals `SIGNATURE` (default 0xBABA). Otherwise `pass` is 0 and `error` is 0.
- R5: A response with `rd_ack`=1 and `rd_err`=1 ends the check in the next cycle with `done`=1, `error`=1, `pass`=0, `busy`=0. No further requests follow.
- R6: An accepted start clears `done`, `pass`, `error` and the sum in the next cycle. Between completion and the next accepted start, `done`, `pass` and `error` hold their values.
- R7: A start pulse while `busy` is 1 is ignored. The running check continues with its address sequence and its verdict unchanged.
- R8: `busy` rises in the cycle after an accepted start and falls in the cycle `done` rises. `busy` and `done` are never both 1.
- R9: `pass` and `error` are never both 1, and neither is 1 while `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check (one-cycle pulse, taken only when idle) |
| rd_req | output | 1 | One-cycle read request for the word at `rd_addr` |
| rd_addr | output | ADDR_W | Word address of the current request |
| rd_ack | input | 1 | Response valid for the outstanding request |
| rd_data | input | DATA_W | Word returned with `rd_ack` |
| rd_err | input | 1 | Read failure flag, qualified by `rd_ack` |
| busy | output | 1 | Check in progress |
| done | output | 1 | Verdict available |
| pass | output | 1 | Sum matched the signature |
| error | output | 1 | Check aborted by a read failure |

## Verification
The bound checker watches several properties on every cycle. It checks the request discipline: one pulse per request, no second request before the answer, and addresses in step with its own counter. It also checks that `busy` and `done` are exclusive, that the verdict flags stay consistent, that a failed read ends the check in one cycle, that the verdict holds while idle, and that a start during a run leaves the run going. Only the bench scenarios can show whether the verdict itself is right. These cover a valid image whose partial sums wrap, an image with one altered word, a read failure part-way through the image, different response latencies, and start pulses sent during a run.

// File: rtl/isc_pkg.sv
package isc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } isc_state_t;

   localparam int unsigned ISC_DEF_WORDS  = 64;
   localparam int unsigned ISC_DEF_DATA_W = 16;
endpackage

// File: rtl/isc_seq.sv
module isc_seq
   import isc_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 64,
   parameter int unsigned ADDR_W    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd_ack,
   input  logic              rd_err,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              busy,
   output logic              clr,
   output logic              take,
   output logic              finish_ok,
   output logic              abort
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS - 1);

   isc_state_t        state_q, state_d;
   logic [ADDR_W-1:0] addr_q,  addr_d;
   logic              at_last;
   logic              resp;

   assign at_last   = (addr_q == LAST_ADDR);
   assign resp      = (state_q == ST_WAIT) && rd_ack;
   assign clr       = (state_q == ST_IDLE) && start;
   assign take      = resp && !rd_err;
   assign abort     = resp && rd_err;
   assign finish_ok = take && at_last;

   always_comb begin
      state_d = state_q;
      addr_d  = addr_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               state_d = ST_ISSUE;
               addr_d  = '0;
            end
         end
         ST_ISSUE: state_d = ST_WAIT;
         ST_WAIT: begin
            if (abort || finish_ok) begin
               state_d = ST_IDLE;
            end else if (take) begin
               state_d = ST_ISSUE;
               addr_d  = addr_q + 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
      end else begin
         state_q <= state_d;
         addr_q  <= addr_d;
      end
   end

   assign rd_req  = (state_q == ST_ISSUE);
   assign rd_addr = addr_q;
   assign busy    = (state_q != ST_IDLE);
endmodule

// File: rtl/isc_accum.sv
module isc_accum #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              take,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] sum_next
);
   logic [DATA_W-1:0] acc_q;

   // carry out of the top bit is dropped: modulo 2^DATA_W
   assign sum_next = acc_q + word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (clr)    acc_q <= '0;
      else if (take)   acc_q <= sum_next;
   end
endmodule

// File: rtl/isc_verdict.sv
module isc_verdict #(
   parameter int unsigned       DATA_W    = 16,
   parameter logic [DATA_W-1:0] SIGNATURE = 16'hBABA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              finish_ok,
   input  logic              abort,
   input  logic [DATA_W-1:0] sum_next,
   output logic              done,
   output logic              pass,
   output logic              error
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done  <= 1'b0;
         pass  <= 1'b0;
         error <= 1'b0;
      end else if (clr) begin
         done  <= 1'b0;
         pass  <= 1'b0;
         error <= 1'b0;
      end else if (abort) begin
         done  <= 1'b1;
         error <= 1'b1;
         pass  <= 1'b0;
      end else if (finish_ok) begin
         done  <= 1'b1;
         error <= 1'b0;
         pass  <= (sum_next == SIGNATURE);
      end
   end
endmodule

// File: rtl/img_sum_checker.sv
module img_sum_checker #(
   parameter int unsigned       NUM_WORDS = isc_pkg::ISC_DEF_WORDS,
   parameter int unsigned       DATA_W    = isc_pkg::ISC_DEF_DATA_W,
   parameter logic [DATA_W-1:0] SIGNATURE = 16'hBABA,
   localparam int unsigned      ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_err,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              error
);
   generate
      if (NUM_WORDS < 2) begin : g_bad_words
         $error("img_sum_checker: NUM_WORDS must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("img_sum_checker: DATA_W must be at least 2");
      end
   endgenerate

   logic clr, take, finish_ok, abort;
   logic [DATA_W-1:0] sum_next;

   isc_seq #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .rd_ack(rd_ack), .rd_err(rd_err),
      .rd_req(rd_req), .rd_addr(rd_addr), .busy(busy),
      .clr(clr), .take(take), .finish_ok(finish_ok), .abort(abort)
   );

   isc_accum #(.DATA_W(DATA_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr), .take(take),
      .word(rd_data), .sum_next(sum_next)
   );

   isc_verdict #(.DATA_W(DATA_W), .SIGNATURE(SIGNATURE)) u_vrd (
      .clk(clk), .rst_n(rst_n), .clr(clr), .finish_ok(finish_ok),
      .abort(abort), .sum_next(sum_next),
      .done(done), .pass(pass), .error(error)
   );
endmodule

// File: rtl/isc_chk.sv
module isc_chk #(
   parameter int unsigned ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              rd_req,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_ack,
   input logic              rd_err,
   input logic              busy,
   input logic              done,
   input logic              pass,
   input logic              error
);
   logic              open_q;
   logic [ADDR_W-1:0] exp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         exp_q  <= '0;
      end else begin
         if (rd_req)      open_q <= 1'b1;
         else if (rd_ack) open_q <= 1'b0;
         if (!busy)       exp_q <= '0;
         else if (rd_req) exp_q <= exp_q + 1'b1;
      end
   end

   // R2
   single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !open_q);
   // R2
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);
   // R2
   addr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> rd_addr == exp_q);
   // R5
   abort_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rd_req && rd_ack && rd_err) |=> (done && error && !pass && !busy));
   // R8
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
   // R9
   verdict_sane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pass || error) |-> (done && !(pass && error)));
   // R6
   verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(pass) && $stable(error)));
   // R7
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !rd_ack) |=> (busy && !done));
endmodule

bind img_sum_checker isc_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
   .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_err(rd_err),
   .busy(busy), .done(done), .pass(pass), .error(error)
);

// File: tb/img_sum_checker_tb.sv
`timescale 1ns/1ps
module img_sum_checker_tb;
   localparam int N = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        rd_req;
   logic [5:0]  rd_addr;
   logic        rd_ack = 1'b0;
   logic [15:0] rd_data = '0;
   logic        rd_err = 1'b0;
   logic        busy, done, pass, error;

   int checks = 0;
   int errors = 0;

   logic [15:0] mem [N];
   int  lat = 0;
   int  err_at = -1;
   int  req_count = 0;
   int  order_bad = 0;
   int  overlap_bad = 0;
   logic pend = 1'b0;
   int   dly = 0;
   logic [5:0] cap_addr = '0;

   always #2.5 clk = ~clk;

   img_sum_checker u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
      .rd_data(rd_data), .rd_err(rd_err),
      .busy(busy), .done(done), .pass(pass), .error(error)
   );

   // memory responder model, driven away from the active edge
   always @(negedge clk) begin
      rd_ack <= 1'b0;
      rd_err <= 1'b0;
      if (pend) begin
         if (rd_req) overlap_bad <= overlap_bad + 1;
         if (dly == 0) begin
            rd_ack  <= 1'b1;
            rd_data <= mem[cap_addr];
            rd_err  <= (int'(cap_addr) == err_at);
            pend    <= 1'b0;
         end else begin
            dly <= dly - 1;
         end
      end else if (rd_req) begin
         if (int'(rd_addr) != req_count) order_bad <= order_bad + 1;
         req_count <= req_count + 1;
         cap_addr  <= rd_addr;
         dly       <= lat;
         pend      <= 1'b1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] fill_image(input logic [15:0] mult);
      logic [15:0] s = '0;
      for (int i = 0; i < N - 1; i++) begin
         mem[i] = 16'(i) * mult + 16'hF00D;
         s = s + mem[i];
      end
      mem[N-1] = 16'hBABA - s;
      return s + mem[N-1];
   endfunction

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_check(input int latency, input int fail_addr, input bit poke_start);
      int guard = 0;
      lat = latency;
      err_at = fail_addr;
      @(negedge clk);
      req_count = 0;
      order_bad = 0;
      overlap_bad = 0;
      pulse_start();
      while (!done && guard < 5000) begin
         @(negedge clk);
         guard++;
         if (poke_start && (guard % 37 == 5)) start = 1'b1;
         else start = 1'b0;
      end
      start = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 pass", pass, 0);
      check("R1 error", error, 0);
      check("R1 rd_req", rd_req, 0);
   endtask

   task automatic t_pass_image(input int latency);
      logic [15:0] s;
      s = fill_image(16'h1357);
      check("R3 bench image sums to signature", s, 16'hBABA);
      run_check(latency, -1, 0);
      check("R4 done after valid image", done, 1);
      check("R4 pass on valid image", pass, 1);
      check("R4 no error on valid image", error, 0);
      check("R8 busy low when done", busy, 0);
      check("R2 request count", req_count, N);
      check("R2 address order", order_bad, 0);
      check("R2 single outstanding", overlap_bad, 0);
   endtask

   task automatic t_corrupt();
      void'(fill_image(16'h2468));
      mem[20] = mem[20] ^ 16'h0100;
      run_check(1, -1, 0);
      check("R4 done on corrupted image", done, 1);
      check("R4 fail on corrupted image", pass, 0);
      check("R4 no error on corrupted image", error, 0);
   endtask

   task automatic t_read_error();
      void'(fill_image(16'h1357));
      run_check(2, 31, 0);
      check("R5 done on read error", done, 1);
      check("R5 error flag", error, 1);
      check("R5 no pass on read error", pass, 0);
      check("R5 busy low after abort", busy, 0);
      check("R5 stopped at failing word", req_count, 32);
      repeat (20) @(negedge clk);
      check("R5 no requests after abort", req_count, 32);
   endtask

   task automatic t_hold_and_restart();
      void'(fill_image(16'h1357));
      run_check(0, -1, 0);
      repeat (25) @(negedge clk);
      check("R6 verdict held done", done, 1);
      check("R6 verdict held pass", pass, 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R6 start clears done", done, 0);
      check("R6 start clears pass", pass, 0);
      check("R8 busy after start", busy, 1);
      begin
         int guard = 0;
         while (!done && guard < 5000) begin @(negedge clk); guard++; end
      end
      check("R6 sum cleared so second run passes", pass, 1);
   endtask

   task automatic t_start_while_busy();
      void'(fill_image(16'h0ACE));
      run_check(1, -1, 1);
      check("R7 run completes", done, 1);
      check("R7 verdict unaffected", pass, 1);
      check("R7 request count unaffected", req_count, N);
      check("R7 order unaffected", order_bad, 0);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pass_image(0);
      t_pass_image(3);
      t_corrupt();
      t_read_error();
      t_hold_and_restart();
      t_start_while_busy();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule